// File: doc/BRIEF.md
# Eight-Point Radix-2 FFT Engine

This block computes an eight-point discrete Fourier transform of complex fixed-point samples. It works in place, with one shared butterfly unit. A host writes the eight input samples one at a time through a load strobe. The block places each sample at the storage slot whose address is the bit-reversed load index, so the decimation-in-time butterflies find their operands in the right places.

A start pulse launches three stages of four butterflies each, at one butterfly per clock. This gives twelve cycles in all. Twiddle factors come from a four-entry constant table in Q1.14 format. In the first stage every twiddle is unity, so that stage bypasses the multiplier.

Every stage halves its outputs, which makes each result one eighth of the true DFT. When the run ends, a one-cycle done pulse tells the host that the read port now returns frequency bin k at address k.

Top module: `fft8_core`

## Requirements
- R1: After a synchronous active-low reset, done is low and every storage word reads back as zero real and zero imaginary.
- R2: A load with index i writes the sample to storage address bitrev(i), where bitrev swaps bit 2 and bit 0 of the 3-bit index. Before a transform, read address a therefore returns the sample loaded with index bitrev(a). While idle and not loading, the storage does not change.
- R3: After a transform, read address k returns bin k of the eight-point DFT of the loaded samples, with twiddle exp(-j2πnk/8), divided by 8. Each real and imaginary part lies within 4 LSB of the exactly rounded value.
- R4: The cycle in which start is sampled high is edge 0. Done is then high for exactly one cycle, right after clock edge 12.
- R5: A start pulse during a running transform is ignored. Done still pulses only once, at the same cycle, and the results are unchanged.
- R6: A load strobe during a running transform is ignored, and the results are those of the samples present when the run began.
- R7: An impulse of value v at index 0, with v a multiple of 8, gives exactly v/8 real and 0 imaginary in every bin.
- R8: With every input part within ±16383, no butterfly sum or difference leaves the 16-bit signed range after its one-bit scaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Sample load strobe |
| ld_idx | input | 3 | Natural-order sample index |
| ld_re | input | 16 | Sample real part, two's complement |
| ld_im | input | 16 | Sample imaginary part, two's complement |
| start | input | 1 | Launches a transform when idle |
| done | output | 1 | One-cycle pulse at end of transform |
| rd_idx | input | 3 | Read address, equal to the bin number after a transform |
| rd_re | output | 16 | Stored real part at rd_idx |
| rd_im | output | 16 | Stored imaginary part at rd_idx |

## Verification
The overflow assertion assumes that each sample part stays within ±16383. Under that bound, the one-bit scaling at every stage keeps butterfly results inside 16 bits even for diagonal twiddles. The other assertions assume that start and ld_en are driven to known levels after reset. Every directed pattern (ramp, single-bin cosine, alternating sign, scattered values and impulse) keeps its amplitudes below 16383. The stimulus changes inputs only at falling edges.

// File: rtl/fft8_pkg.sv
// Shared constants, index type and bit-reversal helper for the FFT engine.
// Assumes a power-of-two size; the twiddle table is written for eight points.
package fft8_pkg;
    localparam int LOG_N = 3;
    localparam int N     = 1 << LOG_N;
    localparam int HALF  = N / 2;
    localparam int STW   = $clog2(LOG_N);

    typedef logic [LOG_N-1:0] idx_t;

    // Mirror the bits of an index.
    function automatic idx_t bitrev(input idx_t v);
        idx_t r;
        for (int i = 0; i < LOG_N; i++) r[i] = v[LOG_N-1-i];
        return r;
    endfunction
endpackage

// File: rtl/fft8_twrom.sv
// Twiddle constants W8^k = cos - j sin, for k in 0..3, in signed Q1.(FRAC).
// Assumes an eight-point transform; entries are computed from FRAC.
module fft8_twrom #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic [fft8_pkg::LOG_N-2:0] k,
    output logic signed [DW-1:0]       w_re,
    output logic signed [DW-1:0]       w_im
);
    localparam int  ONE  = 1 << FRAC;
    localparam real ISQ2 = 0.7071067811865476;
    localparam int  R2   = int'(ISQ2 * real'(ONE));

    // Select the constant pair for the requested twiddle power.
    always_comb begin
        unique case (k)
            2'd0:    begin w_re = DW'(ONE);  w_im = '0;         end
            2'd1:    begin w_re = DW'(R2);   w_im = DW'(-R2);   end
            2'd2:    begin w_re = '0;        w_im = DW'(-ONE);  end
            default: begin w_re = DW'(-R2);  w_im = DW'(-R2);   end
        endcase
    end
endmodule

// File: rtl/fft8_bfly.sv
// Radix-2 butterfly: x = (a + W*b)/2 and y = (a - W*b)/2, truncated.
// With trivial set, W is taken as one and the multiplier is bypassed.
// Assumes operands small enough that the halved results fit DW bits.
module fft8_bfly #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 trivial,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = 2*DW + 2;

    function automatic logic signed [PW-1:0] ext(input logic signed [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    function automatic logic fits(input logic signed [PW-1:0] v);
        return (v[PW-1:DW-1] == '0) || (&v[PW-1:DW-1]);
    endfunction

    logic signed [PW-1:0] p_re, p_im, s_re, s_im, d_re, d_im;

    // Form the twiddled operand, then the halved sum and difference.
    always_comb begin
        if (trivial) begin
            p_re = ext(b_re);
            p_im = ext(b_im);
        end else begin
            p_re = (ext(b_re) * ext(w_re) - ext(b_im) * ext(w_im)) >>> FRAC;
            p_im = (ext(b_re) * ext(w_im) + ext(b_im) * ext(w_re)) >>> FRAC;
        end
        s_re = (ext(a_re) + p_re) >>> 1;
        s_im = (ext(a_im) + p_im) >>> 1;
        d_re = (ext(a_re) - p_re) >>> 1;
        d_im = (ext(a_im) - p_im) >>> 1;
    end

    assign x_re = s_re[DW-1:0];
    assign x_im = s_im[DW-1:0];
    assign y_re = d_re[DW-1:0];
    assign y_im = d_im[DW-1:0];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (fits(s_re) && fits(s_im) && fits(d_re) && fits(d_im)));
endmodule

// File: rtl/fft8_ctrl.sv
// Butterfly sequencer: on start, steps through LOG_N stages of HALF
// butterflies. It gives the two in-place addresses and the twiddle power
// each cycle, then pulses done. Start while busy is ignored.
module fft8_ctrl
    import fft8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output idx_t               addr_top,
    output idx_t               addr_bot,
    output logic [LOG_N-2:0]   tw_k,
    output logic               trivial
);
    logic [STW-1:0]   stage;
    logic [LOG_N-2:0] bfly;
    logic             last;
    idx_t span, pos, grp, kfull;

    assign last    = (stage == STW'(LOG_N-1)) && (bfly == '1);
    assign trivial = (stage == '0);

    // Derive operand addresses and twiddle power from stage and butterfly.
    always_comb begin
        span     = idx_t'(1) << stage;
        pos      = idx_t'(bfly) & (span - idx_t'(1));
        grp      = idx_t'(bfly) >> stage;
        addr_top = (grp << (stage + STW'(1))) | pos;
        addr_bot = addr_top | span;
        kfull    = pos << (STW'(LOG_N-1) - stage);
        tw_k     = kfull[LOG_N-2:0];
    end

    // Run state, step counters and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            stage <= '0;
            bfly  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    stage <= '0;
                    bfly  <= '0;
                end
            end else if (last) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                stage <= '0;
                bfly  <= '0;
            end else begin
                bfly <= bfly + 1'b1;
                if (bfly == '1) stage <= stage + 1'b1;
            end
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> (busy && !done));
endmodule

// File: rtl/fft8_core.sv
// In-place eight-point DIT FFT: a register file loaded at bit-reversed
// addresses, one butterfly per cycle for twelve cycles, and natural-order
// readout. Loads and starts are honoured only while idle.
module fft8_core #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_en,
    input  logic [fft8_pkg::LOG_N-1:0]  ld_idx,
    input  logic [DW-1:0]               ld_re,
    input  logic [DW-1:0]               ld_im,
    input  logic                        start,
    output logic                        done,
    input  logic [fft8_pkg::LOG_N-1:0]  rd_idx,
    output logic [DW-1:0]               rd_re,
    output logic [DW-1:0]               rd_im
);
    import fft8_pkg::*;

    logic [N-1:0][DW-1:0] mem_re, mem_im;
    logic                 busy, trivial;
    idx_t                 a_top, a_bot;
    logic [LOG_N-2:0]     tw_k;
    logic signed [DW-1:0] w_re, w_im, x_re, x_im, y_re, y_im;

    fft8_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .addr_top(a_top), .addr_bot(a_bot), .tw_k(tw_k), .trivial(trivial)
    );

    fft8_twrom #(.DW(DW), .FRAC(FRAC)) u_rom (
        .k(tw_k), .w_re(w_re), .w_im(w_im)
    );

    fft8_bfly #(.DW(DW), .FRAC(FRAC)) u_bfly (
        .clk(clk), .rst_n(rst_n), .en(busy), .trivial(trivial),
        .a_re(mem_re[a_top]), .a_im(mem_im[a_top]),
        .b_re(mem_re[a_bot]), .b_im(mem_im[a_bot]),
        .w_re(w_re), .w_im(w_im),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    // Storage update: clear, butterfly write-back, or bit-reversed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_re <= '0;
            mem_im <= '0;
        end else if (busy) begin
            mem_re[a_top] <= x_re;
            mem_im[a_top] <= x_im;
            mem_re[a_bot] <= y_re;
            mem_im[a_bot] <= y_im;
        end else if (ld_en) begin
            mem_re[bitrev(ld_idx)] <= ld_re;
            mem_im[bitrev(ld_idx)] <= ld_im;
        end
    end

    assign rd_re = mem_re[rd_idx];
    assign rd_im = mem_im[rd_idx];

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ld_en && !start) |=> ($stable(mem_re) && $stable(mem_im)));
endmodule

// File: tb/fft8_core_bench.sv
module fft8_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TOL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_re = '0, ld_im = '0;
    logic        start = 1'b0;
    logic        done;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_re, rd_im;

    int n_checks = 0;
    int n_err = 0;
    int xr[8], xi[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    fft8_core u_fft8_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_re(ld_re), .ld_im(ld_im), .start(start), .done(done),
        .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int brev(input int v);
        return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic load_all();
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 3'(n); ld_re = 16'(xr[n]); ld_im = 16'(xi[n]);
        end
        @(negedge clk); ld_en = 1'b0;
    endtask

    // Pulses start, counts edges after it; optionally injects start and load mid-run.
    task automatic run(input bit inject, output int first_at, output int pulses);
        first_at = 0; pulses = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= 30; k++) begin
            @(posedge clk); @(negedge clk);
            if (done) begin
                pulses++;
                if (first_at == 0) first_at = k;
            end
            if (inject && k == 4) begin
                start = 1'b1; ld_en = 1'b1; ld_idx = 3'd0; ld_re = 16'd7777; ld_im = 16'd7777;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
        end
    endtask

    task automatic check_dft(input string req);
        for (int k = 0; k < 8; k++) begin
            real er = 0.0, ei = 0.0;
            for (int n = 0; n < 8; n++) begin
                real ang = -2.0 * 3.14159265358979 * real'(n * k) / 8.0;
                er += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
                ei += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
            end
            rd_idx = 3'(k);
            #1;
            begin
                int ar = int'($signed(rd_re)), ai = int'($signed(rd_im));
                int xre = rnd(er / 8.0), xim = rnd(ei / 8.0);
                check((ar - xre <= TOL) && (xre - ar <= TOL), req, ar, xre);
                check((ai - xim <= TOL) && (xim - ai <= TOL), req, ai, xim);
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(done == 1'b0, "R1 done", int'(done), 0);
        for (int a = 0; a < 8; a++) begin
            rd_idx = 3'(a); #1;
            check(rd_re == 16'd0 && rd_im == 16'd0, "R1 storage", int'(rd_re), 0);
        end
    endtask

    task automatic t_bitrev();
        for (int n = 0; n < 8; n++) begin xr[n] = n * 100 + 1; xi[n] = -n; end
        load_all();
        repeat (3) @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd_idx = 3'(a); #1;
            check(int'($signed(rd_re)) == xr[brev(a)], "R2 re", int'($signed(rd_re)), xr[brev(a)]);
            check(int'($signed(rd_im)) == xi[brev(a)], "R2 im", int'($signed(rd_im)), xi[brev(a)]);
        end
    endtask

    task automatic t_pattern(input int sel);
        int f, p;
        for (int n = 0; n < 8; n++) begin
            case (sel)
                0: begin xr[n] = n * 1500 - 5000; xi[n] = 3000 - n * 700; end
                1: begin xr[n] = rnd(12000.0 * $cos(2.0 * 3.14159265358979 * real'(n) / 8.0)); xi[n] = 0; end
                2: begin xr[n] = (n % 2 == 0) ? 10000 : -10000; xi[n] = 2000; end
                default: begin xr[n] = ((n * 7919) % 20000) - 10000; xi[n] = ((n * 3571) % 16000) - 8000; end
            endcase
        end
        load_all();
        run(1'b0, f, p);
        check(f == 12, "R4 done edge", f, 12);
        check(p == 1, "R4 single pulse", p, 1);
        check_dft("R3 bin");
    endtask

    task automatic t_impulse();
        int f, p;
        for (int n = 0; n < 8; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 8000;
        load_all();
        run(1'b0, f, p);
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k); #1;
            check(int'($signed(rd_re)) == 1000, "R7 re", int'($signed(rd_re)), 1000);
            check(int'($signed(rd_im)) == 0, "R7 im", int'($signed(rd_im)), 0);
        end
    endtask

    task automatic t_busy_ignore();
        int f, p;
        for (int n = 0; n < 8; n++) begin xr[n] = 4000 - n * 900; xi[n] = n * 650 - 1800; end
        load_all();
        run(1'b1, f, p);
        check(f == 12, "R5 done edge", f, 12);
        check(p == 1, "R5 one pulse", p, 1);
        check_dft("R6 bin");
    endtask

    task automatic t_reset_clears();
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd_idx = 3'(a); #1;
            check(rd_re == 16'd0 && rd_im == 16'd0, "R1 cleared", int'(rd_re), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++; n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_bitrev();
        t_reset();
        t_pattern(0);
        t_pattern(1);
        t_pattern(2);
        t_pattern(3);
        t_impulse();
        t_busy_ignore();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule